// File: doc/BRIEF.md
# Ring Sampling Mode and Protection Controller

This block sits between the frequency synthesizer of a ring generator and its output drivers. It takes the raw push-pull primary drives, named phase A and phase B, and the raw secondary sample strobe. It produces the gated drives that go to the power stage. Every clock it chooses one of two sampling behaviours.

In ring mode the synthesizer's offset-frequency strobe is passed through, so the output carries a low-frequency alias. In DC mode the strobe is ignored. The block then makes its own sample pulse, locked to each rising edge of phase B and delayed by a programmed number of clock ticks. This leaves only a DC level at the output. Toggling the ring request produces cadenced ringing.

The block also applies two protections. A low enable forces every output off. An overcurrent trip blanks all three outputs and stays latched until the next primary half cycle starts with the comparator clear.

Top module: `ring_mode_guard`

## Requirements
- R1: DC mode (encoding 1) is selected when `hook_flag` is high or `ring_req` is low. Ring mode (encoding 0) is selected only when `ring_req` is high and `hook_flag` is low. In ring mode `smp` equals `strobe_raw` one clock later. In DC mode `strobe_raw` has no effect on `smp`.
- R2: The mode and the delay code are sampled only at a rising edge of `pri_b_raw`, which marks the start of a primary period. Changes made between two such edges take effect at the next one.
- R3: In DC mode the sample pulse is PW clocks wide. With PW at its default of 1, the pulse is high in the clock cycle that comes `d` cycles after the one in which `pri_b` first goes high. `d` is the effective delay, so a code of 0 puts the pulse in the same cycle as that `pri_b` rise.
- R4: `dly_code` values 0 to 4 give 0 to 4 ticks of delay. Codes 5, 6 and 7 give 4 ticks.
- R5: A high `ocp_flag` forces `pri_a`, `pri_b` and `smp` low from the next clock on.
- R6: After a trip, all three outputs stay low until a cycle in which a rising edge of either raw primary input is seen while `ocp_flag` is low. From that cycle on, the outputs follow their inputs again.
- R7: A low `drv_en` forces `pri_a`, `pri_b` and `smp` low from the next clock on.
- R8: `pri_a` and `pri_b` are never high together. If both raw primary inputs are high in the same cycle, both outputs go low.
- R9: When the block is not blanked, `pri_a` and `pri_b` follow `pri_a_raw` and `pri_b_raw` with one clock of latency.
- R10: During reset and after it, all outputs are low. The block starts in DC mode and emits no sample pulse until the first rising edge of `pri_b_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick is one delay step |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_req | input | 1 | Ring request; high asks for ringing |
| hook_flag | input | 1 | Off-hook comparator result |
| ocp_flag | input | 1 | Primary overcurrent comparator result |
| drv_en | input | 1 | Output enable; low turns every drive off |
| dly_code | input | DLY_W | DC-mode delay level from the A/D converter |
| pri_a_raw | input | 1 | Raw primary phase A drive |
| pri_b_raw | input | 1 | Raw primary phase B drive |
| strobe_raw | input | 1 | Raw ring-mode sample strobe |
| pri_a | output | 1 | Gated primary phase A drive |
| pri_b | output | 1 | Gated primary phase B drive |
| smp | output | 1 | Gated sample switch drive |

## Verification
A stale mode or delay latch shows up within one primary period as a sample pulse in the wrong cycle, a missing pulse or an extra pulse, counted from the `pri_b` rise. Every delay code is swept against that rise. A trip latch that clears too early lets drive pulses through before the next half-cycle edge. A latch that clears too late keeps the outputs dark after that edge. Both errors show in the first cycles after the trip. Enable, interlock and strobe pass-through faults appear at the outputs one clock after the stimulus.

// File: rtl/ring_guard_pkg.sv
// Shared types for the ring sampling mode and protection controller.
// Assumes nothing beyond a single clock domain.
package ring_guard_pkg;
    typedef enum logic {
        SMP_RING = 1'b0,   // sample strobe passed through (offset sampling)
        SMP_DC   = 1'b1    // locally timed pulse, synchronous to phase B
    } smp_mode_t;
endpackage

// File: rtl/rg_edge.sv
// Rising-edge detector for N synchronous lines.
// Assumes the inputs are already in the clock domain. Rise is combinational:
// it is high in the first cycle a line reads high after reading low.
module rg_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Hold the last sampled level of line i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= din[i];
        end
        assign rise[i] = din[i] & ~prev_q[i];
    end
endmodule

// File: rtl/rg_trip.sv
// Cycle-by-cycle overcurrent latch.
// It sets on any cycle with the comparator high. It clears only in a cycle
// that starts a primary half cycle while the comparator is low.
// trip_now is the value the latch takes at the coming edge.
module rg_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic ocp_flag,
    input  logic half_start,
    output logic trip_now,
    output logic trip_q
);
    assign trip_now = ocp_flag | (trip_q & ~half_start);

    // Store the trip state across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= trip_now;
    end
endmodule

// File: rtl/rg_sched.sv
// Sampling mode selection and DC-mode pulse timing.
// At each period start (rising edge of phase B) it latches the mode and the
// saturated delay. It then counts clock ticks from that edge. smp_req is the
// next value of the sample drive before any blanking: in DC mode it is the
// timed window, in ring mode it is the raw strobe.
// Assumes a primary period longer than MAX_STEPS + PW clocks.
module rg_sched
    import ring_guard_pkg::*;
#(
    parameter int DLY_W     = 3,
    parameter int MAX_STEPS = 4,
    parameter int PW        = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_start,
    input  logic             ring_req,
    input  logic             hook_flag,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             strobe_raw,
    output logic             smp_req
);
    localparam int PH_MAX = MAX_STEPS + PW;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int DQ_W   = $clog2(MAX_STEPS + 1);

    smp_mode_t        mode_q, mode_now, mode_req;
    logic [DQ_W-1:0]  dly_q, dly_now, dly_sat;
    logic [PH_W-1:0]  phase_q, elapsed;
    logic             in_win;

    // Decode the requested mode and saturate the delay code.
    always_comb begin
        mode_req = (hook_flag || !ring_req) ? SMP_DC : SMP_RING;
        dly_sat  = (int'(dly_code) > MAX_STEPS) ? DQ_W'(MAX_STEPS) : DQ_W'(dly_code);
    end

    // Use the fresh values in the cycle the period starts, the latched ones otherwise.
    always_comb begin
        mode_now = period_start ? mode_req : mode_q;
        dly_now  = period_start ? dly_sat  : dly_q;
        elapsed  = period_start ? '0       : phase_q;
        in_win   = (int'(elapsed) >= int'(dly_now)) && (int'(elapsed) < int'(dly_now) + PW);
        smp_req  = (mode_now == SMP_DC) ? in_win : strobe_raw;
    end

    // Latch mode and delay once per primary period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SMP_DC;
            dly_q  <= '0;
        end else if (period_start) begin
            mode_q <= mode_req;
            dly_q  <= dly_sat;
        end
    end

    // Count ticks since the period start, saturating outside any window.
    always_ff @(posedge clk) begin
        if (!rst_n)                  phase_q <= PH_W'(PH_MAX);
        else if (period_start)       phase_q <= PH_W'(1);
        else if (phase_q != PH_W'(PH_MAX)) phase_q <= phase_q + PH_W'(1);
    end

    // R4: the latched delay never exceeds the saturation limit.
    a_r4_dly_sat: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dly_q) <= MAX_STEPS);

    // R2: the latched mode changes only at an edge that started a period.
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(mode_q));
endmodule

// File: rtl/ring_mode_guard.sv
// Top of the ring sampling mode and protection controller.
// It gates the raw primary drives and the sample drive, applying the enable,
// the latched overcurrent blanking and the drive interlock. The sample drive
// comes from rg_sched. All outputs are registered: one clock of latency.
// Assumes the raw primaries are synchronous to clk and that a period starts
// at each rising edge of phase B.
module ring_mode_guard
    import ring_guard_pkg::*;
#(
    parameter int DLY_W     = 3,
    parameter int MAX_STEPS = 4,
    parameter int PW        = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_req,
    input  logic             hook_flag,
    input  logic             ocp_flag,
    input  logic             drv_en,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             pri_a_raw,
    input  logic             pri_b_raw,
    input  logic             strobe_raw,
    output logic             pri_a,
    output logic             pri_b,
    output logic             smp
);
    logic [1:0] rise;
    logic       half_start, period_start;
    logic       trip_now, trip_q;
    logic       smp_req, blank;

    rg_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pri_b_raw, pri_a_raw}),
        .rise (rise)
    );

    assign half_start   = |rise;
    assign period_start = rise[1];

    rg_trip u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .ocp_flag  (ocp_flag),
        .half_start(half_start),
        .trip_now  (trip_now),
        .trip_q    (trip_q)
    );

    rg_sched #(.DLY_W(DLY_W), .MAX_STEPS(MAX_STEPS), .PW(PW)) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_start(period_start),
        .ring_req    (ring_req),
        .hook_flag   (hook_flag),
        .dly_code    (dly_code),
        .strobe_raw  (strobe_raw),
        .smp_req     (smp_req)
    );

    assign blank = trip_now | ~drv_en;

    // Register the gated drives; the interlock drops both phases on overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_a <= 1'b0;
            pri_b <= 1'b0;
            smp   <= 1'b0;
        end else begin
            pri_a <= ~blank & pri_a_raw & ~pri_b_raw;
            pri_b <= ~blank & pri_b_raw & ~pri_a_raw;
            smp   <= ~blank & smp_req;
        end
    end

    // R8: the two primary phases are never driven together.
    a_r8_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_a && pri_b));

    // R7: a low enable turns every output off at the next edge.
    a_r7_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (!pri_a && !pri_b && !smp));

    // R5: a comparator trip blanks every output at the next edge.
    a_r5_ocp_off: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_flag |=> (!pri_a && !pri_b && !smp));

    // R6: a held trip keeps the outputs dark until a half-cycle start.
    a_r6_trip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_q && !half_start) |=> (!pri_a && !pri_b && !smp));
endmodule

// File: tb/ring_mode_guard_bench.sv
// Bench for ring_mode_guard. The primaries run with a 16-tick period: phase A
// is high in ticks 0-7 and phase B in ticks 8-15. Expected outputs are
// computed tick by tick from the requirements.
module ring_mode_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 16;
    localparam int MAXD       = 4;
    localparam int PW         = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring_req = 1'b0, hook_flag = 1'b0, ocp_flag = 1'b0, drv_en = 1'b0;
    logic [2:0] dly_code = 3'd0;
    logic       pri_a_raw = 1'b0, pri_b_raw = 1'b0, strobe_raw = 1'b0;
    logic       pri_a, pri_b, smp;

    int  checks = 0;
    int  errors = 0;
    int  t = 0;
    logic force_both = 1'b0;
    bit  done = 1'b0;

    // Reference model state
    logic prev_a = 1'b0, prev_b = 1'b0;
    logic m_trip = 1'b0, m_dc = 1'b1;
    int   m_d = 0;
    int   since = 99;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_mode_guard u_ring_mode_guard (
        .clk(clk), .rst_n(rst_n), .ring_req(ring_req), .hook_flag(hook_flag),
        .ocp_flag(ocp_flag), .drv_en(drv_en), .dly_code(dly_code),
        .pri_a_raw(pri_a_raw), .pri_b_raw(pri_b_raw), .strobe_raw(strobe_raw),
        .pri_a(pri_a), .pri_b(pri_b), .smp(smp)
    );

    task automatic check(input string what, input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s tick %0d: actual %0b expected %0b", tag, what, t, act, exp);
        end
    endtask

    // Drive one tick, predict it, clock it and compare the outputs.
    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            logic a, b, hs, ps, blank, ea, eb, es;
            a = ((t % PER) < PER/2) || force_both;
            b = ((t % PER) >= PER/2) || force_both;
            pri_a_raw  = a;
            pri_b_raw  = b;
            strobe_raw = ((t % 5) == 2);
            hs = (a && !prev_a) || (b && !prev_b);
            ps = b && !prev_b;
            m_trip = ocp_flag || (m_trip && !hs);
            blank = m_trip || !drv_en;
            if (ps) begin
                m_dc  = hook_flag || !ring_req;
                m_d   = (int'(dly_code) > MAXD) ? MAXD : int'(dly_code);
                since = 0;
            end
            ea = !blank && a && !b;
            eb = !blank && b && !a;
            es = !blank && (m_dc ? (since >= m_d && since < m_d + PW) : strobe_raw);
            @(posedge clk);
            @(negedge clk);
            check("pri_a", tag, pri_a, ea);
            check("pri_b", tag, pri_b, eb);
            check("smp",   tag, smp,   es);
            prev_a = a;
            prev_b = b;
            if (since < 99) since++;
            t++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: outputs are low while reset is held.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("pri_a", "R10", pri_a, 1'b0);
            check("pri_b", "R10", pri_b, 1'b0);
            check("smp",   "R10", smp,   1'b0);
        end
        drv_en = 1'b1;
        rst_n  = 1'b1;
        // R10: no pulse before the first phase B rise; DC mode from ring_req low.
        run(PER, "R10");
        // R3 R4: sweep every delay code in DC mode (off-hook).
        hook_flag = 1'b1;
        for (int c = 0; c < 8; c++) begin
            dly_code = 3'(c);
            run(2*PER, "R3 R4");
        end
        // R1: ring requested but off-hook still selects DC mode.
        ring_req = 1'b1; dly_code = 3'd2;
        run(2*PER, "R1");
        // R1 R9: ring mode passes the strobe and the drives through.
        hook_flag = 1'b0;
        run(3*PER, "R1 R9");
        // R2: a mode change in mid period waits for the next phase B rise.
        run(4, "R2");
        hook_flag = 1'b1;
        run(2*PER - 4, "R2");
        dly_code = 3'd4;
        run(PER + 9, "R2");
        dly_code = 3'd0;
        run(PER + 7, "R2");
        // R2: cadenced ringing by toggling the ring request.
        hook_flag = 1'b0;
        for (int k = 0; k < 4; k++) begin
            ring_req = ~ring_req;
            run(PER + 5, "R2");
        end
        // R5 R6: a one-tick trip in phase A, cleared at the phase B rise.
        ring_req = 1'b0; dly_code = 3'd1;
        while ((t % PER) != 3) run(1, "R5");
        ocp_flag = 1'b1;
        run(1, "R5");
        ocp_flag = 1'b0;
        run(PER, "R6");
        // R6: trip held across a half-cycle start keeps the outputs dark.
        ocp_flag = 1'b1;
        run(10, "R6");
        ocp_flag = 1'b0;
        run(2*PER, "R6");
        // R7: enable low forces everything off.
        drv_en = 1'b0;
        run(12, "R7");
        drv_en = 1'b1;
        run(2*PER, "R7");
        // R8: overlapping raw phases drop both outputs.
        for (int k = 0; k < 3; k++) begin
            force_both = 1'b1;
            run(1, "R8");
            force_both = 1'b0;
            run(5 + k, "R8");
        end
        run(PER, "R8");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule